// File: doc/BRIEF.md
# Mode-Split Translation Buffer with Register-Driven Invalidation

This block caches virtual-to-physical page translations in two separate direct-mapped buffers. One serves user-mode accesses and the other serves supervisor-mode accesses. A lookup presents a virtual address, a 3-bit function code and a read/write flag. One cycle later the block answers with a hit and a physical address, a miss (the walker must fetch the page entry and refill the buffer), or a protection fault. A refill port lets an external page walker install entries. The walker also reports page faults and page-table faults into a status register.

The block owns four control registers on a small register bus that takes 32-bit and 16-bit accesses: two segment table pointers (one per mode), a buffer control register and a command/status register. Invalidation is driven entirely by side effects of register traffic and of the lookup port:
- a longword read of the control register empties both buffers;
- particular values written to the control register empty one buffer;
- writing a segment pointer empties the buffer of that mode;
- a write cycle in the purge address space removes one address from both buffers.

The status register also holds per-mode translation enables, three plain enables for neighbouring units, and sticky fault flags that software clears by writing ones.

Top module: `mode_split_tlb`

## Requirements
- R1: Each mode has its own direct-mapped buffer of 2^IDX_W entries.
  - The index is va[21:12] and the tag is va[31:22] at the default parameters.
  - After a refill with rf_super selecting the buffer, a lookup of the same page in that mode gives rsp_hit=1 and rsp_pa={pfn, va[11:0]}, with rsp_valid high exactly one cycle after the request.
  - The other mode's buffer is not changed by the refill.
- R2: Function code decoding:
  - lk_fc[2]=1 selects the supervisor buffer and lk_fc[2]=0 selects the user buffer.
  - A lookup with lk_fc=3 and lk_write=1 is a purge. It produces no response (rsp_valid stays 0).
- R3: A write that hits a read-only entry gives rsp_prot=1 with rsp_hit=0.
  - A write that hits an entry whose modify bit is clear gives rsp_hit=0 and rsp_prot=0 (a miss).
  - A read of a read-only entry hits.
- R4: Translation enables are in the status register: bit 0 for user and bit 1 for supervisor.
  - When a mode is disabled, its lookups return rsp_hit=1, rsp_pa equal to the virtual address and rsp_ci=0, and never a protection fault.
- R5: A longword read of the control register (offset 0x8) empties both buffers. A word read of it (offset 0xA) empties nothing.
- R6: A longword write of the control register empties one buffer, depending on the value:
  - 0x00000000 empties only the user buffer;
  - 0x00008000 empties only the supervisor buffer;
  - any other value, and any word write, empties nothing.
- R7: Writing the supervisor pointer (offset 0x0) empties the supervisor buffer, and writing the user pointer (offset 0x4) empties the user buffer.
  - Pointer values read back and drive sup_stp and usr_stp.
- R8: A purge invalidates the entry for that address in both buffers when its tag matches. An entry at the same index with a different tag survives.
- R9: Status bits 0, 1, 2, 5 and 6 are plain read/write.
  - Bit 2 drives ext_cache_en, bit 5 drives icache_en and bit 6 drives copro_en.
  - All other bits read as zero, apart from the fault flags of R10.
- R10: Status bits 3, 13, 14 and 15 are sticky fault flags.
  - A protection fault sets 13 and 3; wk_pg_fault sets 14 and 3; wk_pt_fault sets 15 and 3.
  - Writing 1 clears a flag and writing 0 has no effect.
  - A hardware set in the same cycle as a clear wins.
- R11: A 16-bit access at offset +0 reaches register bits 31:16, and one at offset +2 reaches bits 15:0.
  - Word data travels in rb_wdata[15:0] and rb_rdata[15:0].
  - A word write to a pointer also empties that mode's buffer.
- R12: When an invalidation and a refill hit the same buffer in the same cycle, the invalidation wins and the refilled entry is not valid afterwards.
- R13: On a translated hit, rsp_ci returns the cache-inhibit bit of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_fc | input | 3 | Function code (bit 2 supervisor, 3 = purge space) |
| lk_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation available |
| rsp_prot | output | 1 | Write to read-only page |
| rsp_ci | output | 1 | Cache inhibit for the page |
| rsp_pa | output | VA_W | Physical address |
| rf_valid | input | 1 | Refill request |
| rf_super | input | 1 | Refill targets the supervisor buffer |
| rf_va | input | VA_W | Refill virtual address |
| rf_pfn | input | VA_W-PG_W | Refill frame number |
| rf_ro | input | 1 | Refill read-only flag |
| rf_ci | input | 1 | Refill cache-inhibit flag |
| rf_mod | input | 1 | Refill modify flag |
| wk_pg_fault | input | 1 | Walker page fault pulse |
| wk_pt_fault | input | 1 | Walker page-table fault pulse |
| rb_valid | input | 1 | Register access strobe |
| rb_write | input | 1 | Register access is a write |
| rb_long | input | 1 | 32-bit access (0 = 16-bit) |
| rb_addr | input | 4 | Byte offset |
| rb_wdata | input | 32 | Write data |
| rb_rdata | output | 32 | Read data (combinational) |
| sup_stp | output | 32 | Supervisor segment table pointer |
| usr_stp | output | 32 | User segment table pointer |
| ext_cache_en | output | 1 | External cache enable |
| icache_en | output | 1 | Instruction cache enable |
| copro_en | output | 1 | Coprocessor enable |

## Verification
The embedded properties check several things on every cycle:
- a response never carries both a hit and a protection fault;
- a disabled mode passes its address through;
- a purge never produces a response;
- a refill leaves its slot valid unless an invalidation coincides;
- a full invalidation leaves a buffer empty;
- a protection fault always raises its flags;
- a page-fault flag only falls after a software write of one to it.

The directed scenarios are needed for what depends on the exact register traffic: which written values empty which buffer, word versus longword side effects, survival of a same-index entry under purge, and the set-over-clear race on the fault flags.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
    localparam int REG_W  = 32;
    localparam int HALF_W = 16;
    localparam int STAT_W = 16;

    typedef enum logic [1:0] {
        REG_SSTP = 2'd0,
        REG_USTP = 2'd1,
        REG_TCTL = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    localparam int ST_UEN  = 0;
    localparam int ST_SEN  = 1;
    localparam int ST_XCE  = 2;
    localparam int ST_BERR = 3;
    localparam int ST_ICE  = 5;
    localparam int ST_CPE  = 6;
    localparam int ST_PROT = 13;
    localparam int ST_PGF  = 14;
    localparam int ST_PTF  = 15;

    localparam logic [STAT_W-1:0] STAT_RW_MASK = 16'h0067;
    localparam logic [STAT_W-1:0] STAT_STICKY  = 16'hE008;

    localparam logic [REG_W-1:0] TCTL_USR_CODE = 32'h0000_0000;
    localparam logic [REG_W-1:0] TCTL_SUP_CODE = 32'h0000_8000;

    localparam logic [2:0] FC_PURGE = 3'd3;
endpackage

// File: rtl/dtlb_bank.sv
module dtlb_bank #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 10,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PFN_W-1:0] rd_pfn,
    output logic             rd_ro,
    output logic             rd_ci,
    output logic             rd_mod,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic             wr_ro,
    input  logic             wr_ci,
    input  logic             wr_mod,
    input  logic             inv_all,
    input  logic             inv_one,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
        logic             ro;
        logic             ci;
        logic             mod;
    } entry_t;

    entry_t           ent_mem [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;
    entry_t           rd_ent, inv_ent;

    always_comb begin
        rd_ent  = ent_mem[rd_idx];
        inv_ent = ent_mem[inv_idx];
        rd_hit  = vld_q[rd_idx] && (rd_ent.tag == rd_tag);
        rd_pfn  = rd_ent.pfn;
        rd_ro   = rd_ent.ro;
        rd_ci   = rd_ent.ci;
        rd_mod  = rd_ent.mod;

        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
        if (inv_one && vld_q[inv_idx] && (inv_ent.tag == inv_tag)) vld_d[inv_idx] = 1'b0;
        if (inv_all) vld_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_mem[wr_idx] <= '{tag: wr_tag, pfn: wr_pfn, ro: wr_ro, ci: wr_ci, mod: wr_mod};
    end

    // R1: a refill with no coinciding invalidation leaves its slot valid
    p_fill_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all && !inv_one) |=> vld_q[$past(wr_idx)]);

    // R12: a full invalidation wins over any refill in the same cycle
    p_flush_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (vld_q == '0));
endmodule

// File: rtl/dtlb_regs.sv
module dtlb_regs
    import dtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb_valid,
    input  logic             rb_write,
    input  logic             rb_long,
    input  logic [3:0]       rb_addr,
    input  logic [REG_W-1:0] rb_wdata,
    output logic [REG_W-1:0] rb_rdata,
    input  logic             hw_prot,
    input  logic             hw_pgf,
    input  logic             hw_ptf,
    output logic             flush_usr,
    output logic             flush_sup,
    output logic [REG_W-1:0] sstp,
    output logic [REG_W-1:0] ustp,
    output logic             xlat_usr_en,
    output logic             xlat_sup_en,
    output logic             ext_cache_en,
    output logic             icache_en,
    output logic             copro_en
);
    typedef struct packed {
        logic [REG_W-1:0]  sstp;
        logic [REG_W-1:0]  ustp;
        logic [STAT_W-1:0] stat;
    } regs_t;

    regs_t             r_d, r_q;
    reg_sel_e          sel;
    logic              wr, rd;
    logic [REG_W-1:0]  wd_al, wm, cur;
    logic [STAT_W-1:0] hw_set, clr;

    always_comb begin
        sel = reg_sel_e'(rb_addr[3:2]);
        wr  = rb_valid && rb_write;
        rd  = rb_valid && !rb_write;

        if (rb_long) begin
            wd_al = rb_wdata;
            wm    = '1;
        end else if (rb_addr[1]) begin
            wd_al = {{HALF_W{1'b0}}, rb_wdata[HALF_W-1:0]};
            wm    = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        end else begin
            wd_al = {rb_wdata[HALF_W-1:0], {HALF_W{1'b0}}};
            wm    = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
        end

        case (sel)
            REG_SSTP: cur = r_q.sstp;
            REG_USTP: cur = r_q.ustp;
            REG_STAT: cur = {{(REG_W-STAT_W){1'b0}}, r_q.stat};
            default:  cur = '0;
        endcase

        rb_rdata = '0;
        if (rd) begin
            if (rb_long)         rb_rdata = cur;
            else if (rb_addr[1]) rb_rdata = {{HALF_W{1'b0}}, cur[HALF_W-1:0]};
            else                 rb_rdata = {{HALF_W{1'b0}}, cur[REG_W-1:HALF_W]};
        end

        hw_set = '0;
        if (hw_prot) begin hw_set[ST_PROT] = 1'b1; hw_set[ST_BERR] = 1'b1; end
        if (hw_pgf)  begin hw_set[ST_PGF]  = 1'b1; hw_set[ST_BERR] = 1'b1; end
        if (hw_ptf)  begin hw_set[ST_PTF]  = 1'b1; hw_set[ST_BERR] = 1'b1; end

        r_d       = r_q;
        clr       = '0;
        flush_usr = 1'b0;
        flush_sup = 1'b0;
        if (wr) begin
            case (sel)
                REG_SSTP: begin
                    r_d.sstp  = (r_q.sstp & ~wm) | (wd_al & wm);
                    flush_sup = 1'b1;
                end
                REG_USTP: begin
                    r_d.ustp  = (r_q.ustp & ~wm) | (wd_al & wm);
                    flush_usr = 1'b1;
                end
                REG_TCTL: begin
                    if (rb_long && rb_wdata == TCTL_USR_CODE) flush_usr = 1'b1;
                    if (rb_long && rb_wdata == TCTL_SUP_CODE) flush_sup = 1'b1;
                end
                default: begin
                    r_d.stat = (r_q.stat & ~wm[STAT_W-1:0] & STAT_RW_MASK)
                             | (wd_al[STAT_W-1:0] & wm[STAT_W-1:0] & STAT_RW_MASK)
                             | (r_q.stat & STAT_STICKY);
                    clr      = wd_al[STAT_W-1:0] & wm[STAT_W-1:0] & STAT_STICKY;
                end
            endcase
        end
        if (rd && rb_long && sel == REG_TCTL) begin
            flush_usr = 1'b1;
            flush_sup = 1'b1;
        end
        r_d.stat = (r_d.stat & ~clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sstp         = r_q.sstp;
    assign ustp         = r_q.ustp;
    assign xlat_usr_en  = r_q.stat[ST_UEN];
    assign xlat_sup_en  = r_q.stat[ST_SEN];
    assign ext_cache_en = r_q.stat[ST_XCE];
    assign icache_en    = r_q.stat[ST_ICE];
    assign copro_en     = r_q.stat[ST_CPE];

    // R10: a protection fault always raises its flag and the bus-error flag
    p_prot_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_prot |=> (r_q.stat[ST_PROT] && r_q.stat[ST_BERR]));

    // R10: the page-fault flag only falls after a write of one to it
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.stat[ST_PGF]) |->
            $past(wr && sel == REG_STAT && wd_al[ST_PGF] && wm[ST_PGF]));
endmodule

// File: rtl/dtlb_resp.sv
module dtlb_resp
    import dtlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PG_W  = 12,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [2:0]       lk_fc,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             usr_en,
    input  logic             sup_en,
    input  logic [1:0]       b_hit,
    input  logic [PFN_W-1:0] pfn_usr,
    input  logic [PFN_W-1:0] pfn_sup,
    input  logic [1:0]       b_ro,
    input  logic [1:0]       b_ci,
    input  logic [1:0]       b_mod,
    output logic             purge,
    output logic             prot_evt,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_prot,
    output logic             rsp_ci,
    output logic [VA_W-1:0]  rsp_pa
);
    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            prot;
        logic            ci;
        logic [VA_W-1:0] pa;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic             msel, look, en, match;
    logic [PFN_W-1:0] pfn;

    always_comb begin
        msel     = lk_fc[2];
        purge    = lk_valid && lk_write && (lk_fc == FC_PURGE);
        look     = lk_valid && !purge;
        en       = msel ? sup_en : usr_en;
        match    = b_hit[msel];
        pfn      = msel ? pfn_sup : pfn_usr;
        prot_evt = look && en && match && lk_write && b_ro[msel];

        rsp_d       = '0;
        rsp_d.valid = look;
        if (look) begin
            if (!en) begin
                rsp_d.hit = 1'b1;
                rsp_d.pa  = lk_va;
            end else if (match) begin
                if (lk_write && b_ro[msel]) begin
                    rsp_d.prot = 1'b1;
                end else if (!(lk_write && !b_mod[msel])) begin
                    rsp_d.hit = 1'b1;
                    rsp_d.ci  = b_ci[msel];
                    rsp_d.pa  = {pfn, lk_va[PG_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_prot  = rsp_q.prot;
    assign rsp_ci    = rsp_q.ci;
    assign rsp_pa    = rsp_q.pa;

    // R3: a response is never both a hit and a protection fault
    p_hit_excl_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_q.hit && rsp_q.prot));

    // R4: a lookup in a disabled mode returns its own address
    p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (look && !en) |=> (rsp_q.hit && !rsp_q.prot && rsp_q.pa == $past(lk_va)));
endmodule

// File: rtl/mode_split_tlb.sv
module mode_split_tlb
    import dtlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PG_W  = 12,
    parameter int IDX_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [2:0]           lk_fc,
    input  logic                 lk_write,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_prot,
    output logic                 rsp_ci,
    output logic [VA_W-1:0]      rsp_pa,
    input  logic                 rf_valid,
    input  logic                 rf_super,
    input  logic [VA_W-1:0]      rf_va,
    input  logic [VA_W-PG_W-1:0] rf_pfn,
    input  logic                 rf_ro,
    input  logic                 rf_ci,
    input  logic                 rf_mod,
    input  logic                 wk_pg_fault,
    input  logic                 wk_pt_fault,
    input  logic                 rb_valid,
    input  logic                 rb_write,
    input  logic                 rb_long,
    input  logic [3:0]           rb_addr,
    input  logic [31:0]          rb_wdata,
    output logic [31:0]          rb_rdata,
    output logic [31:0]          sup_stp,
    output logic [31:0]          usr_stp,
    output logic                 ext_cache_en,
    output logic                 icache_en,
    output logic                 copro_en
);
    localparam int PFN_W = VA_W - PG_W;
    localparam int TAG_W = VA_W - PG_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] lk_tag, rf_tag;
    logic             flush_usr, flush_sup, usr_en, sup_en, purge, prot_evt;
    logic [1:0]       b_hit, b_ro, b_ci, b_mod, b_inv_all, b_wr;
    logic [PFN_W-1:0] b_pfn [2];

    assign lk_idx = lk_va[PG_W +: IDX_W];
    assign lk_tag = lk_va[VA_W-1 -: TAG_W];
    assign rf_idx = rf_va[PG_W +: IDX_W];
    assign rf_tag = rf_va[VA_W-1 -: TAG_W];

    dtlb_regs u_regs (
        .clk, .rst_n,
        .rb_valid, .rb_write, .rb_long, .rb_addr, .rb_wdata, .rb_rdata,
        .hw_prot      (prot_evt),
        .hw_pgf       (wk_pg_fault),
        .hw_ptf       (wk_pt_fault),
        .flush_usr, .flush_sup,
        .sstp         (sup_stp),
        .ustp         (usr_stp),
        .xlat_usr_en  (usr_en),
        .xlat_sup_en  (sup_en),
        .ext_cache_en, .icache_en, .copro_en
    );

    // bank 0 serves user mode, bank 1 supervisor mode
    for (genvar m = 0; m < 2; m++) begin : g_bank
        assign b_inv_all[m] = (m == 1) ? flush_sup : flush_usr;
        assign b_wr[m]      = rf_valid && (rf_super == (m == 1));

        dtlb_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_bank (
            .clk, .rst_n,
            .rd_idx  (lk_idx),
            .rd_tag  (lk_tag),
            .rd_hit  (b_hit[m]),
            .rd_pfn  (b_pfn[m]),
            .rd_ro   (b_ro[m]),
            .rd_ci   (b_ci[m]),
            .rd_mod  (b_mod[m]),
            .wr_en   (b_wr[m]),
            .wr_idx  (rf_idx),
            .wr_tag  (rf_tag),
            .wr_pfn  (rf_pfn),
            .wr_ro   (rf_ro),
            .wr_ci   (rf_ci),
            .wr_mod  (rf_mod),
            .inv_all (b_inv_all[m]),
            .inv_one (purge),
            .inv_idx (lk_idx),
            .inv_tag (lk_tag)
        );
    end

    dtlb_resp #(.VA_W(VA_W), .PG_W(PG_W), .PFN_W(PFN_W)) u_resp (
        .clk, .rst_n,
        .lk_valid, .lk_write, .lk_fc, .lk_va,
        .usr_en, .sup_en,
        .b_hit,
        .pfn_usr (b_pfn[0]),
        .pfn_sup (b_pfn[1]),
        .b_ro, .b_ci, .b_mod,
        .purge, .prot_evt,
        .rsp_valid, .rsp_hit, .rsp_prot, .rsp_ci, .rsp_pa
    );

    // R2: a purge-space write never produces a response
    p_purge_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_write && lk_fc == FC_PURGE) |=> !rsp_valid);
endmodule

// File: tb/mode_split_tlb_bench.sv
module mode_split_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [31:0] lk_va = '0;
    logic [2:0]  lk_fc = '0;
    logic        rsp_valid, rsp_hit, rsp_prot, rsp_ci;
    logic [31:0] rsp_pa;
    logic        rf_valid = 0, rf_super = 0, rf_ro = 0, rf_ci = 0, rf_mod = 0;
    logic [31:0] rf_va = '0;
    logic [19:0] rf_pfn = '0;
    logic        wk_pg_fault = 0, wk_pt_fault = 0;
    logic        rb_valid = 0, rb_write = 0, rb_long = 0;
    logic [3:0]  rb_addr = '0;
    logic [31:0] rb_wdata = '0, rb_rdata, sup_stp, usr_stp;
    logic        ext_cache_en, icache_en, copro_en;

    int n_chk = 0, n_bad = 0;

    localparam logic [31:0] VA_A = 32'h0040_3000;
    localparam logic [31:0] VA_B = 32'h0080_3000;
    localparam logic [31:0] VA_C = 32'h0100_5000;
    localparam logic [31:0] VA_D = 32'h0200_7000;
    localparam logic [2:0]  FC_U = 3'd1, FC_S = 3'd5, FC_P = 3'd3;

    always #2 clk = ~clk;

    mode_split_tlb u_mode_split_tlb (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] va, input logic [2:0] fc, input logic wr);
        lk_valid = 1; lk_va = va; lk_fc = fc; lk_write = wr;
        tick();
        lk_valid = 0; lk_write = 0;
    endtask

    task automatic refill(input logic sup, input logic [31:0] va, input logic [19:0] pfn,
                          input logic ro, input logic ci, input logic md);
        rf_valid = 1; rf_super = sup; rf_va = va; rf_pfn = pfn;
        rf_ro = ro; rf_ci = ci; rf_mod = md;
        tick();
        rf_valid = 0;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic lg, input logic [31:0] d);
        rb_valid = 1; rb_write = 1; rb_long = lg; rb_addr = a; rb_wdata = d;
        tick();
        rb_valid = 0; rb_write = 0;
    endtask

    task automatic reg_rd(input logic [3:0] a, input logic lg, output logic [31:0] d);
        rb_valid = 1; rb_write = 0; rb_long = lg; rb_addr = a;
        #1 d = rb_rdata;
        tick();
        rb_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_rd(4'hC, 1, v); chk("R9 reset status", v, 32'h0);
        reg_rd(4'h0, 1, v); chk("R7 reset sup ptr", v, 32'h0);
        chk("R9 reset enables", {ext_cache_en, icache_en, copro_en}, 3'b000);
        lookup(32'h1234_5678, FC_U, 0);
        chk("R4 reset pass-through", {rsp_valid, rsp_hit}, 2'b11);
        chk("R4 reset pass pa", rsp_pa, 32'h1234_5678);
        reg_wr(4'hC, 1, 32'h3);
    endtask

    task automatic t_refill_hit;
        refill(0, VA_A, 20'hABCDE, 0, 1, 1);
        lookup(VA_A | 32'h123, FC_U, 0);
        chk("R1 user hit valid", {rsp_valid, rsp_hit}, 2'b11);
        chk("R1 user hit pa", rsp_pa, 32'hABCD_E123);
        chk("R13 ci returned", rsp_ci, 1'b1);
        lookup(VA_A, FC_S, 0);
        chk("R2 super buffer separate", {rsp_valid, rsp_hit}, 2'b10);
    endtask

    task automatic t_write_policy;
        logic [31:0] v;
        refill(1, VA_C, 20'h11111, 1, 0, 1);
        lookup(VA_C, FC_S, 0);
        chk("R3 read of ro hits", {rsp_hit, rsp_prot}, 2'b10);
        lookup(VA_C, FC_S, 1);
        chk("R3 write to ro faults", {rsp_hit, rsp_prot}, 2'b01);
        reg_rd(4'hC, 1, v); chk("R10 prot flags set", v, 32'h200B);
        reg_wr(4'hC, 1, 32'h200B);
        reg_rd(4'hC, 1, v); chk("R10 w1c clears", v, 32'h0003);
        refill(0, VA_D, 20'h22222, 0, 0, 0);
        lookup(VA_D, FC_U, 1);
        chk("R3 write clean page misses", {rsp_valid, rsp_hit, rsp_prot}, 3'b100);
        lookup(VA_D, FC_U, 0);
        chk("R3 read clean page hits", rsp_hit, 1'b1);
    endtask

    task automatic t_passthru;
        logic [31:0] v;
        reg_wr(4'hC, 1, 32'h1);
        lookup(VA_C | 32'hABC, FC_S, 1);
        chk("R4 disabled no fault", {rsp_hit, rsp_prot, rsp_ci}, 3'b100);
        chk("R4 disabled pa", rsp_pa, VA_C | 32'hABC);
        reg_rd(4'hC, 1, v); chk("R4 no flag when disabled", v, 32'h1);
        reg_wr(4'hC, 1, 32'h3);
        lookup(VA_C | 32'hABC, FC_S, 0);
        chk("R4 re-enabled translates", rsp_pa, 32'h1111_1ABC);
    endtask

    task automatic t_flush_read;
        logic [31:0] v;
        reg_rd(4'hA, 0, v);
        lookup(VA_A, FC_U, 0); chk("R5 word read keeps user", rsp_hit, 1'b1);
        reg_rd(4'h8, 1, v);
        lookup(VA_A, FC_U, 0); chk("R5 long read flushes user", rsp_hit, 1'b0);
        lookup(VA_C, FC_S, 0); chk("R5 long read flushes super", rsp_hit, 1'b0);
    endtask

    task automatic t_flush_ctl;
        refill(0, VA_A, 20'hABCDE, 0, 0, 1);
        refill(1, VA_C, 20'h11111, 0, 0, 1);
        reg_wr(4'h8, 1, 32'h1234);
        reg_wr(4'hA, 0, 32'h0);
        lookup(VA_A, FC_U, 0); chk("R6 other value keeps user", rsp_hit, 1'b1);
        lookup(VA_C, FC_S, 0); chk("R6 word write keeps super", rsp_hit, 1'b1);
        reg_wr(4'h8, 1, 32'h8000);
        lookup(VA_C, FC_S, 0); chk("R6 0x8000 flushes super", rsp_hit, 1'b0);
        lookup(VA_A, FC_U, 0); chk("R6 0x8000 keeps user", rsp_hit, 1'b1);
        refill(1, VA_C, 20'h11111, 0, 0, 1);
        reg_wr(4'h8, 1, 32'h0);
        lookup(VA_A, FC_U, 0); chk("R6 zero flushes user", rsp_hit, 1'b0);
        lookup(VA_C, FC_S, 0); chk("R6 zero keeps super", rsp_hit, 1'b1);
    endtask

    task automatic t_ptr;
        logic [31:0] v;
        refill(0, VA_A, 20'hABCDE, 0, 0, 1);
        reg_wr(4'h0, 1, 32'h55);
        lookup(VA_C, FC_S, 0); chk("R7 sup ptr flushes super", rsp_hit, 1'b0);
        lookup(VA_A, FC_U, 0); chk("R7 sup ptr keeps user", rsp_hit, 1'b1);
        reg_rd(4'h0, 1, v); chk("R7 sup ptr readback", v, 32'h55);
        chk("R7 sup ptr output", sup_stp, 32'h55);
        reg_wr(4'h4, 1, 32'h66);
        lookup(VA_A, FC_U, 0); chk("R7 user ptr flushes user", rsp_hit, 1'b0);
        chk("R7 user ptr output", usr_stp, 32'h66);
    endtask

    task automatic t_word;
        logic [31:0] v;
        refill(0, VA_A, 20'hABCDE, 0, 0, 1);
        reg_wr(4'h4, 0, 32'h1234);
        reg_wr(4'h6, 0, 32'hABCD);
        chk("R11 word halves merge", usr_stp, 32'h1234_ABCD);
        reg_rd(4'h4, 0, v); chk("R11 word read high", v, 32'h1234);
        reg_rd(4'h6, 0, v); chk("R11 word read low", v, 32'hABCD);
        lookup(VA_A, FC_U, 0); chk("R11 word ptr write flushes", rsp_hit, 1'b0);
    endtask

    task automatic t_purge;
        refill(0, VA_A, 20'hAAAAA, 0, 0, 1);
        refill(1, VA_A, 20'hBBBBB, 0, 0, 1);
        lookup(VA_B, FC_P, 1);
        chk("R2 purge gives no response", rsp_valid, 1'b0);
        lookup(VA_A, FC_U, 0); chk("R8 other tag survives user", rsp_hit, 1'b1);
        lookup(VA_A, FC_S, 0); chk("R8 other tag survives super", rsp_pa, 32'hBBBB_B000);
        lookup(VA_A | 32'h44, FC_P, 1);
        lookup(VA_A, FC_U, 0); chk("R8 purge clears user", rsp_hit, 1'b0);
        lookup(VA_A, FC_S, 0); chk("R8 purge clears super", rsp_hit, 1'b0);
    endtask

    task automatic t_ctl_bits;
        logic [31:0] v;
        reg_wr(4'hC, 1, 32'hFFFF_FFFF);
        reg_rd(4'hC, 1, v); chk("R9 rw bits only", v, 32'h0067);
        chk("R9 enables high", {ext_cache_en, icache_en, copro_en}, 3'b111);
        reg_wr(4'hC, 1, 32'h3);
        chk("R9 enables low", {ext_cache_en, icache_en, copro_en}, 3'b000);
    endtask

    task automatic t_sticky;
        logic [31:0] v;
        wk_pg_fault = 1; tick(); wk_pg_fault = 0;
        reg_rd(4'hC, 1, v); chk("R10 page fault flags", v, 32'h400B);
        reg_wr(4'hC, 1, 32'h3);
        reg_rd(4'hC, 1, v); chk("R10 writing zero keeps flags", v, 32'h400B);
        wk_pt_fault = 1; tick(); wk_pt_fault = 0;
        reg_rd(4'hC, 1, v); chk("R10 table fault flag", v, 32'hC00B);
        wk_pg_fault = 1;
        reg_wr(4'hC, 1, 32'hC00B);
        wk_pg_fault = 0;
        reg_rd(4'hC, 1, v); chk("R10 set wins over clear", v, 32'h400B);
        reg_wr(4'hE, 0, 32'h400B);
        reg_rd(4'hC, 1, v); chk("R10 word clear", v, 32'h0003);
    endtask

    task automatic t_conflict;
        rf_valid = 1; rf_super = 0; rf_va = VA_A; rf_pfn = 20'h77777;
        rf_ro = 0; rf_ci = 0; rf_mod = 1;
        rb_valid = 1; rb_write = 1; rb_long = 1; rb_addr = 4'h8; rb_wdata = 32'h0;
        tick();
        rf_valid = 0; rb_valid = 0; rb_write = 0;
        lookup(VA_A, FC_U, 0); chk("R12 invalidate beats refill", rsp_hit, 1'b0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_refill_hit();
        t_write_policy();
        t_passthru();
        t_flush_read();
        t_flush_ctl();
        t_ptr();
        t_word();
        t_purge();
        t_ctl_bits();
        t_sticky();
        t_conflict();
        summary();
        $finish;
    end
endmodule